// File: doc/BRIEF.md
# Frame-Buffer Scan-Out Address Controller

This block sits between a raster timing generator, an asynchronous SRAM frame buffer and a flat-panel display. On every rising pixel-clock edge it registers the incoming horizontal and vertical sync strobes, together with the combined visible-area strobe. The combined strobe is the AND of the horizontal and vertical not-blanking inputs. The block presents a linear read address to the SRAM. That address moves forward only over visible pixels, so pixel k of a frame is read from address k.

The address changes on the rising edge. The panel latches the returned pixel on the falling edge, so the SRAM access must complete within half a pixel period. Pixel data reaches the panel through a path with no register and is forced to zero outside the visible area. The address returns to zero at the start of every vertical blanking interval.

A mode input switches the outputs to a VGA-style connection. In that mode the pixel clock output is held low and the data-enable pin carries a composite blanking level. The syncs keep their behaviour.

Top module: `fb_scanout_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `sram_addr` to 0, `de_out` to 0 in panel mode, `pix_data_out` to 0, and `hsync_out` and `vsync_out` to 1, starting in the cycle after the reset edge.
- R2: The internal data enable is `h_active & v_active`, registered once. In panel mode (`vga_mode`=0), `de_out` equals the value of that AND at the previous rising edge.
- R3: `sram_addr` rises by exactly one at each rising edge that ends a cycle in which the registered data enable is 1. At every other edge it holds, except where R5 applies. As a result, the visible pixel with index k in the frame is read from address k.
- R4: `sram_addr` never exceeds H_ACTIVE*V_ACTIVE-1. If more visible pixels arrive than that count, the address holds at H_ACTIVE*V_ACTIVE-1.
- R5: When `v_active` is sampled 0 at a rising edge after it was sampled 1 at the edge before, `sram_addr` becomes 0 from that edge on. This clear takes priority over the increment.
- R6: `pix_data_out` equals `sram_data` with no register in between while the registered data enable is 1, and is 0 otherwise. It is therefore valid at the falling edge that follows.
- R7: `hsync_out` and `vsync_out` each equal their input as sampled at the previous rising edge.
- R8: With `vga_mode`=1, `pix_clk_out` is held at 0 and `de_out` is the inverse of the registered data enable (1 during blanking). With `vga_mode`=0, `pix_clk_out` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vga_mode | input | 1 | 1 selects VGA-style outputs, 0 selects panel outputs |
| h_active | input | 1 | Horizontal not-blanking from the timing generator, active high |
| v_active | input | 1 | Vertical not-blanking from the timing generator, active high |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| sram_data | input | DATA_W | Pixel word returned by the frame-buffer SRAM |
| sram_addr | output | ADDR_W | Linear frame-buffer read address |
| pix_clk_out | output | 1 | Pixel clock to the panel; held low in VGA mode |
| de_out | output | 1 | Data enable in panel mode; composite blanking in VGA mode |
| hsync_out | output | 1 | Registered horizontal sync |
| vsync_out | output | 1 | Registered vertical sync |
| pix_data_out | output | DATA_W | Pixel word to the panel; zero outside the visible area |

## Verification
The hardest state to reach is saturation of the address at the last frame location, followed by its release at the next vertical blanking. A correctly timed raster never drives the address past the last frame location. The bench therefore shrinks the visible area through parameters and then drives one frame with two extra visible lines. This holds the address at its limit for two full lines before the clear. A normal frame follows, which shows that addressing restarts from zero. The SRAM is modelled as returning the address plus one. This makes the forced-zero data outside the visible area distinguishable from a real read of address 0, and lets each sample taken at the falling edge be compared against the linear index.

// File: rtl/fb_scanout_ctrl.sv
module fb_scanout_ctrl #(
  parameter int H_ACTIVE = 600,
  parameter int V_ACTIVE = 600,
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vga_mode,
  input  logic              h_active,
  input  logic              v_active,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [DATA_W-1:0] sram_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              pix_clk_out,
  output logic              de_out,
  output logic              hsync_out,
  output logic              vsync_out,
  output logic [DATA_W-1:0] pix_data_out
);

  localparam int FRAME_PIXELS = H_ACTIVE * V_ACTIVE;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_PIXELS - 1);

  logic              de_q, v_q, hs_q, vs_q;
  logic [ADDR_W-1:0] addr_q;
  logic              vblank_start;

  assign vblank_start = v_q & ~v_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q   <= 1'b0;
      v_q    <= 1'b0;
      hs_q   <= 1'b1;
      vs_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      de_q <= h_active & v_active;
      v_q  <= v_active;
      hs_q <= hsync_in;
      vs_q <= vsync_in;
      if (vblank_start)
        addr_q <= '0;
      else if (de_q && addr_q != LAST_ADDR)
        addr_q <= addr_q + 1'b1;
    end
  end

  assign sram_addr    = addr_q;
  assign hsync_out    = hs_q;
  assign vsync_out    = vs_q;
  assign de_out       = vga_mode ? ~de_q : de_q;
  assign pix_clk_out  = vga_mode ? 1'b0 : clk;
  assign pix_data_out = de_q ? sram_data : '0;

  // R2
  de_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (h_active && v_active) |=> (de_out != vga_mode));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!de_q && !(v_q && !v_active)) |=> $stable(sram_addr));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    sram_addr <= LAST_ADDR);

  // R5
  vblank_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (v_q && !v_active) |=> (sram_addr == '0));

  // R6
  pix_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(h_active && v_active) |=> (pix_data_out == '0));

  // R7
  sync_reg_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hsync_out == $past(hsync_in) && vsync_out == $past(vsync_in)));

endmodule

// File: tb/fb_scanout_ctrl_tb.sv
module fb_scanout_ctrl_tb_top;
  localparam int H_ACT = 40, V_ACT = 30, H_TOT = 50, V_TOT = 36;
  localparam int AW = 19, DW = 24;
  localparam int LAST = H_ACT * V_ACT - 1;

  logic clk = 1'b0, rst = 1'b1, vga_mode = 1'b0;
  logic h_active = 1'b0, v_active = 1'b0, hsync_in = 1'b1, vsync_in = 1'b1;
  logic [DW-1:0] sram_data, pix_data_out;
  logic [AW-1:0] sram_addr;
  logic pix_clk_out, de_out, hsync_out, vsync_out;

  always #5 clk = ~clk;

  assign sram_data = DW'(sram_addr) + DW'(1);

  fb_scanout_ctrl #(.H_ACTIVE(H_ACT), .V_ACTIVE(V_ACT), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .vga_mode(vga_mode), .h_active(h_active), .v_active(v_active),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .sram_data(sram_data), .sram_addr(sram_addr),
    .pix_clk_out(pix_clk_out), .de_out(de_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .pix_data_out(pix_data_out));

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {vga, h, v, hs, vs, exp_de, exp_hs, exp_vs}
  localparam logic [7:0] VEC [8] = '{
    8'b0_11_11_111, 8'b0_10_10_010, 8'b0_01_01_001, 8'b0_00_00_000,
    8'b1_11_11_011, 8'b1_01_11_111, 8'b1_10_00_100, 8'b1_00_10_110};

  int cat_err [6];
  longint cat_act [6], cat_exp [6];
  string cat_name [6] = '{"R3 address", "R6 pixel", "R2 data enable",
                          "R7 sync", "R5 vblank clear", "R4 saturation"};
  bit p_de, p_hs, p_vs, p_v, pp_v;
  longint nxt;

  task automatic note(input int c, input bit ok, input longint act, input longint exp);
    if (!ok) begin
      if (cat_err[c] == 0) begin cat_act[c] = act; cat_exp[c] = exp; end
      cat_err[c]++;
    end
  endtask

  task automatic run_frame(input int v_lines);
    for (int c = 0; c < 6; c++) cat_err[c] = 0;
    for (int vc = 0; vc < V_TOT; vc++) begin
      for (int hc = 0; hc < H_TOT; hc++) begin
        @(posedge clk);
        #1;
        h_active = (hc < H_ACT);
        v_active = (vc < v_lines);
        hsync_in = !(hc >= 42 && hc < 46);
        vsync_in = !(vc >= v_lines + 2 && vc < v_lines + 4);
        #5;
        if (!p_v && pp_v) begin
          nxt = 0;
          note(4, sram_addr == 0, sram_addr, 0);
        end
        note(nxt == LAST ? 5 : 0, sram_addr == nxt, sram_addr, nxt);
        note(1, pix_data_out == (p_de ? nxt + 1 : 0), pix_data_out, p_de ? nxt + 1 : 0);
        note(2, de_out == p_de, de_out, p_de);
        note(3, {hsync_out, vsync_out} == {p_hs, p_vs}, {hsync_out, vsync_out}, {p_hs, p_vs});
        if (p_de && nxt < LAST) nxt++;
        pp_v = p_v; p_v = v_active; p_de = h_active & v_active;
        p_hs = hsync_in; p_vs = vsync_in;
      end
    end
    for (int c = 0; c < 6; c++)
      if (c != 5 || v_lines > V_ACT)
        chk(cat_err[c] == 0, cat_name[c], cat_act[c], cat_exp[c]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(sram_addr == 0, "R1 addr", sram_addr, 0);
    chk(de_out == 0, "R1 de_out", de_out, 0);
    chk(pix_data_out == 0, "R1 pixel", pix_data_out, 0);
    chk({hsync_out, vsync_out} == 2'b11, "R1 syncs", {hsync_out, vsync_out}, 3);
    rst = 1'b0;

    // R2 R7 R8 R6 table walk
    foreach (VEC[i]) begin
      @(posedge clk);
      #1;
      {vga_mode, h_active, v_active, hsync_in, vsync_in} = VEC[i][7:3];
      @(posedge clk);
      #2;
      chk(de_out == VEC[i][2], "R2/R8 de_out", de_out, VEC[i][2]);
      chk({hsync_out, vsync_out} == VEC[i][1:0], "R7 sync", {hsync_out, vsync_out}, VEC[i][1:0]);
      chk(pix_data_out == ((VEC[i][6] & VEC[i][5]) ? DW'(sram_addr) + 1 : 0), "R6 pixel",
          pix_data_out, (VEC[i][6] & VEC[i][5]) ? DW'(sram_addr) + 1 : 0);
      chk(pix_clk_out == !vga_mode, "R8 pix_clk high phase", pix_clk_out, !vga_mode);
      #5;
      chk(pix_clk_out == 0, "R8 pix_clk low phase", pix_clk_out, 0);
    end

    // clean restart in blanking
    @(posedge clk);
    #1;
    vga_mode = 0; h_active = 0; v_active = 0; hsync_in = 1; vsync_in = 1; rst = 1;
    @(posedge clk);
    #1;
    rst = 0;
    p_de = 0; p_hs = 1; p_vs = 1; p_v = 0; pp_v = 0; nxt = 0;

    run_frame(V_ACT);
    run_frame(V_ACT);
    run_frame(V_ACT + 2);   // R4: two surplus lines hold the address at its limit
    run_frame(V_ACT);

    // R1 reset during visible area
    @(posedge clk);
    #1;
    h_active = 1; v_active = 1; rst = 1;
    @(posedge clk);
    #2;
    chk(sram_addr == 0, "R1 addr mid-frame", sram_addr, 0);
    chk(de_out == 0, "R1 de_out mid-frame", de_out, 0);
    chk(pix_data_out == 0, "R1 pixel mid-frame", pix_data_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule